// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation lookaside buffer in which every entry holds one tag for a pair of adjacent virtual pages. Each half of the pair has its own physical frame, valid bit and dirty bit. A lookup takes a 32-bit virtual address, a load/store flag and the current 8-bit address-space identifier. It returns a result code, the translated physical address and read/write permission. The lookup is purely combinational.

Entries are loaded through a synchronous write port that names an index. An entry flagged global matches under any address-space identifier. A per-entry page mask widens the page pair beyond the minimum of two 4 KiB pages. The result code tells the caller which kind of refill or fault handling is needed: no entry matched, the selected half is invalid, or a store hit a clean half.

Top module: `pair_tlb`

## Requirements
- R1: After an active-low asynchronous reset every entry is empty, so every lookup returns NOMATCH (3'b110) with `rd_o`=0, `wr_o`=0 and `pa_o`=0 until an entry is written.
- R2: An entry takes part in a lookup only if its global bit is set or its stored identifier equals `asid_i`. A non-global entry whose identifier differs returns NOMATCH.
- R3: The effective mask is the entry's page mask ORed with 0x1FFF. Virtual-address bits and stored page-number bits under the effective mask are ignored in the tag compare.
- R4: The half is chosen by the highest address bit under the effective mask: bit 12 for a zero page mask, bit 14 for page mask 0x6000. A 0 in that bit selects the even half and a 1 selects the odd half.
- R5: If the selected half's valid bit is clear, the result is INVALID (3'b101) for loads and for stores. This check takes precedence over the dirty check.
- R6: A store to a valid half whose dirty bit is clear returns DIRTY (3'b100). A load to the same half returns MATCH with `wr_o`=0.
- R7: On MATCH (3'b000), `pa_o` equals the selected half's frame value ORed with the address bits under the effective mask shifted right by one. `rd_o` is 1, and `wr_o` equals that half's dirty bit.
- R8: When several entries match, the lowest-indexed entry supplies the result.
- R9: For every result other than MATCH, `pa_o`, `rd_o` and `wr_o` are all zero. The only codes produced are 000, 110, 101 and 100. The code 111 (bad address) is reserved.
- R10: An entry write takes effect at the clock edge where `wr_en_i` is high, and it replaces the whole entry at `wr_idx_i`. Lookups reflect the new contents from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write entry at `wr_idx_i` |
| wr_idx_i | input | 4 | Entry index for the write |
| wr_vpn_i | input | 32 | Virtual page-pair number (bits under the mask are don't-care) |
| wr_pmask_i | input | 32 | Page mask added to the 0x1FFF minimum |
| wr_asid_i | input | 8 | Address-space identifier of the entry |
| wr_global_i | input | 1 | Entry matches any identifier |
| wr_pfn0_i | input | 32 | Even-half frame address |
| wr_pfn1_i | input | 32 | Odd-half frame address |
| wr_v0_i | input | 1 | Even-half valid |
| wr_v1_i | input | 1 | Odd-half valid |
| wr_d0_i | input | 1 | Even-half dirty (writable) |
| wr_d1_i | input | 1 | Odd-half dirty (writable) |
| va_i | input | 32 | Virtual address to translate |
| asid_i | input | 8 | Current address-space identifier |
| store_i | input | 1 | 1 for a store, 0 for a load |
| res_o | output | 3 | Result code |
| pa_o | output | 32 | Physical address |
| rd_o | output | 1 | Read permitted |
| wr_o | output | 1 | Write permitted |

## Verification
Several properties are checked on every cycle. A failed lookup never leaks an address or a permission. A store can only match a writable half, and DIRTY only appears for stores. Only legal codes appear. No lookup hits between reset and the first write. The bench scenarios cover what depends on table contents: identifier and global matching, mask widening, choice of the even or odd half, translated address values, lowest-index priority, precedence of the invalid check over the dirty check, and an overwrite of an entry.

// File: rtl/ptlb_pkg.sv
`timescale 1ns/1ps
package ptlb_pkg;
  typedef enum logic [2:0] {
    RES_MATCH   = 3'b000,
    RES_BADADDR = 3'b111,
    RES_NOMATCH = 3'b110,
    RES_INVALID = 3'b101,
    RES_DIRTY   = 3'b100
  } tlb_res_e;
endpackage

// File: rtl/ptlb_store.sv
`timescale 1ns/1ps
module ptlb_store #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VA_W-1:0]   wr_vpn_i,
  input  logic [VA_W-1:0]   wr_pmask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PA_W-1:0]   wr_pfn0_i,
  input  logic [PA_W-1:0]   wr_pfn1_i,
  input  logic              wr_v0_i,
  input  logic              wr_v1_i,
  input  logic              wr_d0_i,
  input  logic              wr_d1_i,
  output logic [VA_W-1:0]   vpn_o   [ENTRIES],
  output logic [VA_W-1:0]   pmask_o [ENTRIES],
  output logic [ASID_W-1:0] asid_o  [ENTRIES],
  output logic [PA_W-1:0]   pfn0_o  [ENTRIES],
  output logic [PA_W-1:0]   pfn1_o  [ENTRIES],
  output logic [ENTRIES-1:0] live_o,
  output logic [ENTRIES-1:0] glob_o,
  output logic [ENTRIES-1:0] v0_o,
  output logic [ENTRIES-1:0] v1_o,
  output logic [ENTRIES-1:0] d0_o,
  output logic [ENTRIES-1:0] d1_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    // control bits reset so an empty table never hits
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_o[g] <= 1'b0;
        v0_o[g]   <= 1'b0;
        v1_o[g]   <= 1'b0;
        d0_o[g]   <= 1'b0;
        d1_o[g]   <= 1'b0;
        glob_o[g] <= 1'b0;
      end else if (sel) begin
        live_o[g] <= 1'b1;
        v0_o[g]   <= wr_v0_i;
        v1_o[g]   <= wr_v1_i;
        d0_o[g]   <= wr_d0_i;
        d1_o[g]   <= wr_d1_i;
        glob_o[g] <= wr_global_i;
      end
    end

    // payload needs no reset
    always_ff @(posedge clk_i) begin
      if (sel) begin
        vpn_o[g]   <= wr_vpn_i;
        pmask_o[g] <= wr_pmask_i;
        asid_o[g]  <= wr_asid_i;
        pfn0_o[g]  <= wr_pfn0_i;
        pfn1_o[g]  <= wr_pfn1_i;
      end
    end
  end
endmodule

// File: rtl/ptlb_match.sv
`timescale 1ns/1ps
module ptlb_match #(
  parameter int VA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              live_i,
  input  logic              glob_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VA_W-1:0]   vpn_i,
  input  logic [VA_W-1:0]   pmask_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic              odd_o,
  output logic [VA_W-1:0]   half_o
);
  localparam logic [VA_W-1:0] PAIR_MASK = (VA_W'(1) << (PAGE_BITS + 1)) - VA_W'(1);

  logic [VA_W-1:0] eff;
  logic            id_ok;

  assign eff    = pmask_i | PAIR_MASK;
  assign half_o = eff >> 1;
  assign id_ok  = glob_i || (ent_asid_i == asid_i);
  assign hit_o  = live_i && id_ok && ((vpn_i & ~eff) == (va_i & ~eff));
  // top bit of the pair mask picks even/odd
  assign odd_o  = |(va_i & eff & ~half_o);
endmodule

// File: rtl/ptlb_pick.sv
`timescale 1ns/1ps
module ptlb_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptlb_resolve.sv
`timescale 1ns/1ps
module ptlb_resolve #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            any_i,
  input  logic            odd_i,
  input  logic            v0_i,
  input  logic            v1_i,
  input  logic            d0_i,
  input  logic            d1_i,
  input  logic [PA_W-1:0] pfn0_i,
  input  logic [PA_W-1:0] pfn1_i,
  input  logic [VA_W-1:0] half_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            store_i,
  output logic [2:0]      res_o,
  output logic [PA_W-1:0] pa_o,
  output logic            rd_o,
  output logic            wr_o
);
  import ptlb_pkg::*;

  logic            v_sel, d_sel;
  logic [PA_W-1:0] pfn_sel;

  assign v_sel   = odd_i ? v1_i   : v0_i;
  assign d_sel   = odd_i ? d1_i   : d0_i;
  assign pfn_sel = odd_i ? pfn1_i : pfn0_i;

  always_comb begin
    res_o = RES_NOMATCH;
    pa_o  = '0;
    rd_o  = 1'b0;
    wr_o  = 1'b0;
    if (any_i) begin
      if (!v_sel) begin
        res_o = RES_INVALID;
      end else if (store_i && !d_sel) begin
        res_o = RES_DIRTY;
      end else begin
        res_o = RES_MATCH;
        pa_o  = pfn_sel | PA_W'(va_i & half_i);
        rd_o  = 1'b1;
        wr_o  = d_sel;
      end
    end
  end
endmodule

// File: rtl/pair_tlb.sv
`timescale 1ns/1ps
module pair_tlb #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VA_W-1:0]   wr_vpn_i,
  input  logic [VA_W-1:0]   wr_pmask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PA_W-1:0]   wr_pfn0_i,
  input  logic [PA_W-1:0]   wr_pfn1_i,
  input  logic              wr_v0_i,
  input  logic              wr_v1_i,
  input  logic              wr_d0_i,
  input  logic              wr_d1_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              store_i,
  output logic [2:0]        res_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              rd_o,
  output logic              wr_o
);
  logic [VA_W-1:0]    vpn   [ENTRIES];
  logic [VA_W-1:0]    pmask [ENTRIES];
  logic [ASID_W-1:0]  easid [ENTRIES];
  logic [PA_W-1:0]    pfn0  [ENTRIES];
  logic [PA_W-1:0]    pfn1  [ENTRIES];
  logic [VA_W-1:0]    half  [ENTRIES];
  logic [ENTRIES-1:0] live, glob, v0, v1, d0, d1, hit, odd;

  logic [IDX_W-1:0]   sel_idx;
  logic               any_hit;

  ptlb_store #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_pmask_i, .wr_asid_i,
    .wr_global_i, .wr_pfn0_i, .wr_pfn1_i, .wr_v0_i, .wr_v1_i, .wr_d0_i, .wr_d1_i,
    .vpn_o(vpn), .pmask_o(pmask), .asid_o(easid), .pfn0_o(pfn0), .pfn1_o(pfn1),
    .live_o(live), .glob_o(glob), .v0_o(v0), .v1_o(v1), .d0_o(d0), .d1_o(d1)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    ptlb_match #(.VA_W(VA_W), .ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)) u_match (
      .live_i(live[g]), .glob_i(glob[g]), .ent_asid_i(easid[g]), .vpn_i(vpn[g]),
      .pmask_i(pmask[g]), .va_i(va_i), .asid_i(asid_i),
      .hit_o(hit[g]), .odd_o(odd[g]), .half_o(half[g])
    );
  end

  ptlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit_i(hit), .idx_o(sel_idx), .any_o(any_hit)
  );

  ptlb_resolve #(.VA_W(VA_W), .PA_W(PA_W)) u_resolve (
    .any_i(any_hit), .odd_i(odd[sel_idx]),
    .v0_i(v0[sel_idx]), .v1_i(v1[sel_idx]), .d0_i(d0[sel_idx]), .d1_i(d1[sel_idx]),
    .pfn0_i(pfn0[sel_idx]), .pfn1_i(pfn1[sel_idx]), .half_i(half[sel_idx]),
    .va_i(va_i), .store_i(store_i),
    .res_o(res_o), .pa_o(pa_o), .rd_o(rd_o), .wr_o(wr_o)
  );
endmodule

// File: rtl/pair_tlb_chk.sv
`timescale 1ns/1ps
module pair_tlb_chk #(
  parameter int PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            store_i,
  input logic [2:0]      res_o,
  input logic [PA_W-1:0] pa_o,
  input logic            rd_o,
  input logic            wr_o
);
  import ptlb_pkg::*;

  logic seen_wr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_wr <= 1'b0;
    else if (wr_en_i) seen_wr <= 1'b1;
  end

  assert_empty_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_wr |-> res_o == RES_NOMATCH);

  assert_fail_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o != RES_MATCH |-> (!rd_o && !wr_o && pa_o == '0));

  assert_legal_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o inside {RES_MATCH, RES_NOMATCH, RES_INVALID, RES_DIRTY});

  assert_match_reads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o == RES_MATCH |-> rd_o);

  assert_store_writable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && res_o == RES_MATCH) |-> wr_o);

  assert_dirty_only_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o == RES_DIRTY |-> store_i);
endmodule

bind pair_tlb pair_tlb_chk #(.PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .store_i(store_i),
  .res_o(res_o), .pa_o(pa_o), .rd_o(rd_o), .wr_o(wr_o)
);

// File: tb/pair_tlb_tb_top.sv
`timescale 1ns/1ps
module pair_tlb_tb_top;
  localparam logic [2:0] C_MATCH = 3'b000, C_NOMATCH = 3'b110,
                         C_INVALID = 3'b101, C_DIRTY = 3'b100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_vpn_i = '0, wr_pmask_i = '0, wr_pfn0_i = '0, wr_pfn1_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic        wr_global_i = 1'b0, wr_v0_i = 1'b0, wr_v1_i = 1'b0;
  logic        wr_d0_i = 1'b0, wr_d1_i = 1'b0;
  logic [31:0] va_i = '0;
  logic [7:0]  asid_i = '0;
  logic        store_i = 1'b0;
  logic [2:0]  res_o;
  logic [31:0] pa_o;
  logic        rd_o, wr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  res;
    logic [31:0] pa;
    logic        rd;
    logic        wr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk_i = ~clk_i;

  pair_tlb dut_i (.*);

  task automatic put_entry(input logic [3:0] idx, input logic [31:0] vpn, input logic [31:0] pm,
                           input logic [7:0] asid, input logic g,
                           input logic [31:0] p0, input logic v0, input logic d0,
                           input logic [31:0] p1, input logic v1, input logic d1);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_vpn_i = vpn; wr_pmask_i = pm; wr_asid_i = asid;
    wr_global_i = g; wr_pfn0_i = p0; wr_v0_i = v0; wr_d0_i = d0;
    wr_pfn1_i = p1; wr_v1_i = v1; wr_d1_i = d1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // driver: apply a lookup and queue its expected result
  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st,
                      input logic [2:0] res, input logic [31:0] pa, input logic rd,
                      input logic wr, input string tag);
    exp_t e;
    @(negedge clk_i);
    va_i = va; asid_i = asid; store_i = st;
    e.res = res; e.pa = pa; e.rd = rd; e.wr = wr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare one queued item per cycle, after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (res_o !== e.res || pa_o !== e.pa || rd_o !== e.rd || wr_o !== e.wr) begin
          n_fail++;
          $display("FAIL %s: got res=%b pa=%h rd=%b wr=%b, expected res=%b pa=%h rd=%b wr=%b",
                   e.tag, res_o, pa_o, rd_o, wr_o, e.res, e.pa, e.rd, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty after reset
    look(32'h0040_0123, 8'h11, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R1 empty table");

    put_entry(4'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0,
              32'h0010_0000, 1'b1, 1'b1, 32'h0020_0000, 1'b1, 1'b0);
    // R4/R7: even and odd halves with a 4 KiB pair
    look(32'h0040_0123, 8'h11, 1'b0, C_MATCH, 32'h0010_0123, 1'b1, 1'b1, "R7 even load");
    look(32'h0040_1ABC, 8'h11, 1'b0, C_MATCH, 32'h0020_0ABC, 1'b1, 1'b0, "R4 odd load clean R6");
    look(32'h0040_1ABC, 8'h11, 1'b1, C_DIRTY, 32'h0, 1'b0, 1'b0, "R6 store to clean half");
    look(32'h0040_0004, 8'h11, 1'b1, C_MATCH, 32'h0010_0004, 1'b1, 1'b1, "R7 store to dirty half");
    look(32'h0040_0123, 8'h12, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R2 identifier mismatch");
    look(32'h0040_2000, 8'h11, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R9 next pair misses");

    // R3: 16 KiB pages, stored page number has junk under the mask, global
    put_entry(4'd1, 32'h1000_7ABC, 32'h0000_6000, 8'h55, 1'b1,
              32'h0300_0000, 1'b1, 1'b1, 32'h0400_0000, 1'b0, 1'b1);
    look(32'h1000_2345, 8'h99, 1'b0, C_MATCH, 32'h0300_2345, 1'b1, 1'b1, "R2 global R3 wide mask");
    look(32'h1000_4010, 8'h99, 1'b0, C_INVALID, 32'h0, 1'b0, 1'b0, "R5 odd invalid load R4");
    look(32'h1000_4010, 8'h99, 1'b1, C_INVALID, 32'h0, 1'b0, 1'b0, "R5 invalid beats dirty");

    // R8: two entries cover the same pair
    put_entry(4'd2, 32'h2000_0000, 32'h0, 8'h11, 1'b0,
              32'h0500_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    put_entry(4'd3, 32'h2000_0000, 32'h0, 8'h00, 1'b1,
              32'h0600_0000, 1'b1, 1'b1, 32'h0, 1'b0, 1'b0);
    look(32'h2000_0010, 8'h11, 1'b0, C_MATCH, 32'h0500_0010, 1'b1, 1'b1, "R8 lower index wins");
    look(32'h2000_0010, 8'h22, 1'b0, C_MATCH, 32'h0600_0010, 1'b1, 1'b1, "R8 fallback to global");

    // R10: write then overwrite the top entry
    look(32'h3000_1008, 8'h11, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R10 before write");
    put_entry(4'd15, 32'h3000_0000, 32'h0, 8'h11, 1'b0,
              32'h0, 1'b0, 1'b0, 32'h0700_0000, 1'b1, 1'b1);
    look(32'h3000_1008, 8'h11, 1'b1, C_MATCH, 32'h0700_0008, 1'b1, 1'b1, "R10 after write");
    put_entry(4'd15, 32'h3000_0000, 32'h0, 8'h11, 1'b0,
              32'h0, 1'b0, 1'b0, 32'h0700_0000, 1'b0, 1'b1);
    look(32'h3000_1008, 8'h11, 1'b0, C_INVALID, 32'h0, 1'b0, 1'b0, "R10 overwrite");

    // R1: reset again clears the table
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    look(32'h0040_0123, 8'h11, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R1 cleared by reset");
    look(32'h1000_2345, 8'h99, 1'b0, C_NOMATCH, 32'h0, 1'b0, 1'b0, "R1 global cleared");

    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule